// File: doc/BRIEF.md
# Tree pseudo-LRU way selector

This block keeps replacement history for a set-associative cache. It holds one binary-tree pseudo-LRU word for each set, and the number of ways must be a power of two. The cache controller sends it two kinds of request on one valid/ready channel:

- A **pick** request names a set. The block walks that set's tree to choose a victim way. In the same acceptance cycle it records that way as most recently used.
- A **touch** request names a set and a way. The controller sends it on a hit, so that the way is recorded as recently used.

The victim leaves through a registered valid/ready result channel. Requests to different sets, or to the same set, may arrive on consecutive cycles. Each accepted request updates the state before the next one is read, so no forwarding is needed.

Back-pressure works as follows:

- A request is accepted in a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is high when the result slot is empty, or when its content is being taken in that cycle.
- While a result is held and `res_ready` is low, the result stays unchanged and no request is accepted. No state changes in that time.

With a single way the block keeps no state and always returns way 0.

Top module: `tree_plru_picker`

## Requirements
- R1: After reset every set's tree word is zero, `res_valid` is 0 and `req_ready` is 1. A pick on any set after reset returns way NUM_WAYS-1.
- R2: Tree nodes are numbered from 0 at the root. A pick walks from node 0. At each of log2(NUM_WAYS) levels it reads flag f at the current node, takes !f as the next way bit (most significant first), and moves to node 2*n+f+1. With 4 ways and a zero word, the result is way 3.
- R3: An accepted pick updates its set exactly as a touch of the chosen victim would. From reset, four picks on one 4-way set return 3, 1, 2, 0, and a fifth returns 3.
- R4: An accepted touch walks from node 0. For each way bit b, taken from the MSB down, it writes node n to b and moves to node 2*n+2-b. Example: after the first pick leaves set 0's word at nodes {0:1,1:1,2:0}, touching way 1 on set 0 makes the next pick on that set return way 2.
- R5: A request changes only the tree word of the set in `req_set`. A pick on another set returns the value that set's own history gives.
- R6: The victim of a pick accepted at a clock edge appears on `res_way`, with `res_valid` high, after that edge.
- R7: `req_ready` = !res_valid || res_ready. While `res_valid` is high and `res_ready` is low, `res_way` and `res_valid` hold their values and a waiting request changes no state.
- R8: With NUM_WAYS = 1 every pick returns way 0 and touches have no effect.
- R9: `req_op` = 1 selects pick and 0 selects touch. An accepted touch produces no result: after it, `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 1 | 1 = pick victim, 0 = touch way |
| req_set | input | SET_W | Set index |
| req_way | input | WAY_W | Way to mark on a touch |
| res_valid | output | 1 | Victim result present |
| res_ready | input | 1 | Consumer takes the result |
| res_way | output | WAY_W | Victim way index |

## Verification
The assertions check several rules on every cycle:

- the stall hold of the result channel;
- that each accepted pick yields a result on the next cycle;
- that a touch yields none;
- that the root node of the addressed set flips on a pick and follows the way's MSB on a touch;
- that the victim's MSB is the inverse of the root flag read.

Only the bench scenarios can show the following:

- the full multi-level walk order;
- the 3-1-2-0 victim cycle;
- isolation between sets;
- back-to-back requests to one set;
- the effect of a touch on a later pick;
- the single-way variant;
- that a held request leaves the state untouched.

// File: rtl/plru_pkg.sv
package plru_pkg;
  typedef enum logic {
    OP_TOUCH = 1'b0,
    OP_PICK  = 1'b1
  } plru_op_e;
endpackage

// File: rtl/plru_walk.sv
// Combinational victim walk over one tree word.
module plru_walk #(
  parameter int NUM_WAYS = 4,
  localparam int DEPTH = $clog2(NUM_WAYS),
  localparam int NODES = NUM_WAYS - 1,
  localparam int IDX_W = DEPTH + 1
) (
  input  logic [NODES-1:0] word,
  output logic [DEPTH-1:0] victim
);
  logic [2*NUM_WAYS-1:0] padded;
  logic [IDX_W-1:0]      idx;
  logic                  flag;

  assign padded = {{(NUM_WAYS+1){1'b0}}, word};

  always_comb begin
    idx    = '0;
    victim = '0;
    flag   = 1'b0;
    for (int lvl = 0; lvl < DEPTH; lvl++) begin
      flag                   = padded[idx];
      victim[DEPTH-1-lvl]    = ~flag;
      idx = {idx[IDX_W-2:0], 1'b0} + IDX_W'(flag) + IDX_W'(1);
    end
  end
endmodule

// File: rtl/plru_mark.sv
// Combinational recency update: mark one way as recently used.
module plru_mark #(
  parameter int NUM_WAYS = 4,
  localparam int DEPTH = $clog2(NUM_WAYS),
  localparam int NODES = NUM_WAYS - 1,
  localparam int IDX_W = DEPTH + 1
) (
  input  logic [NODES-1:0] word,
  input  logic [DEPTH-1:0] way,
  output logic [NODES-1:0] word_next
);
  logic [2*NUM_WAYS-1:0] work;
  logic [IDX_W-1:0]      idx;
  logic                  bit_b;

  always_comb begin
    work  = {{(NUM_WAYS+1){1'b0}}, word};
    idx   = '0;
    bit_b = 1'b0;
    for (int lvl = 0; lvl < DEPTH; lvl++) begin
      bit_b     = way[DEPTH-1-lvl];
      work[idx] = bit_b;
      idx = {idx[IDX_W-2:0], 1'b0} + (bit_b ? IDX_W'(1) : IDX_W'(2));
    end
    word_next = work[NODES-1:0];
  end
endmodule

// File: rtl/plru_store.sv
// One tree word per set, written on request acceptance.
module plru_store #(
  parameter int NUM_SETS = 8,
  parameter int NODES    = 3,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SET_W-1:0]              wr_set,
  input  logic [NODES-1:0]              wr_word,
  output logic [NUM_SETS-1:0][NODES-1:0] words
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
    end else if (wr_en) begin
      words[wr_set] <= wr_word;
    end
  end
endmodule

// File: rtl/tree_plru_picker.sv
module tree_plru_picker
  import plru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [SET_W-1:0] req_set,
  input  logic [WAY_W-1:0] req_way,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WAY_W-1:0] res_way
);
  plru_op_e   op;
  logic       accept;
  logic       acc_pick;
  logic       acc_touch;
  logic [WAY_W-1:0] victim;

  assign op        = plru_op_e'(req_op);
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;
  assign acc_pick  = accept && (op == OP_PICK);
  assign acc_touch = accept && (op == OP_TOUCH);

  generate
    if (NUM_WAYS > 1) begin : g_tree
      localparam int NODES = NUM_WAYS - 1;
      logic [NUM_SETS-1:0][NODES-1:0] words;
      logic [NODES-1:0] cur_word;
      logic [NODES-1:0] next_word;
      logic [WAY_W-1:0] mark_way;

      assign cur_word = words[req_set];
      assign mark_way = (op == OP_PICK) ? victim : req_way;

      plru_walk #(.NUM_WAYS(NUM_WAYS)) u_walk (
        .word   (cur_word),
        .victim (victim)
      );

      plru_mark #(.NUM_WAYS(NUM_WAYS)) u_mark (
        .word      (cur_word),
        .way       (mark_way),
        .word_next (next_word)
      );

      plru_store #(.NUM_SETS(NUM_SETS), .NODES(NODES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_set  (req_set),
        .wr_word (next_word),
        .words   (words)
      );

      // R2
      pick_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pick |=> res_way[WAY_W-1] == !$past(cur_word[0]));
      // R3
      pick_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pick |=> words[$past(req_set)][0] != $past(cur_word[0]));
      // R4
      touch_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_touch |=> words[$past(req_set)][0] == $past(req_way[WAY_W-1]));
    end else begin : g_single
      logic unused_single;
      assign unused_single = ^{req_set, req_way};
      assign victim = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_way   <= '0;
    end else if (acc_pick) begin
      res_valid <= 1'b1;
      res_way   <= victim;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R6
  pick_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pick |=> res_valid);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_way)));
  // R9
  touch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_touch |=> !res_valid);
endmodule

// File: tb/tree_plru_picker_test.sv
module tree_plru_picker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // {op, set[2:0], way[1:0], expected victim[1:0]}
  localparam logic [7:0] VEC [NV] = '{
    8'b1_000_00_11, 8'b1_000_00_01, 8'b1_000_00_10, 8'b1_000_00_00,
    8'b1_000_00_11, 8'b0_000_01_00, 8'b1_000_00_10, 8'b1_101_00_11,
    8'b1_000_00_00, 8'b0_010_00_00, 8'b1_010_00_11, 8'b0_011_11_00,
    8'b1_011_00_01, 8'b0_111_10_00, 8'b1_111_00_01
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0, res_ready = 1'b1;
  logic [2:0] req_set = '0;
  logic [1:0] req_way = '0;
  logic req_ready, res_valid, req_ready1, res_valid1;
  logic [1:0] res_way;
  logic [0:0] res_way1;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tree_plru_picker #(.NUM_WAYS(4), .NUM_SETS(8)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_set(req_set), .req_way(req_way),
    .res_valid(res_valid), .res_ready(res_ready), .res_way(res_way));

  tree_plru_picker #(.NUM_WAYS(1), .NUM_SETS(8)) uut1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready1),
    .req_op(req_op), .req_set(req_set), .req_way(req_way[0]),
    .res_valid(res_valid1), .res_ready(res_ready), .res_way(res_way1));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit op, input int s, input int w);
    req_valid = v; req_op = op; req_set = 3'(s); req_way = 2'(w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of the ports
    check(res_valid == 0, "R1 res_valid after reset", res_valid, 0);
    check(req_ready == 1, "R1 req_ready after reset", req_ready, 1);
    rst_n = 1'b1;

    // Table walk: one request per cycle, results checked the following cycle
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (VEC[i-1][7]) begin
          // R2 R3 R5: victim order, marking, set isolation
          check(res_valid == 1, $sformatf("R6 vec %0d valid", i-1), res_valid, 1);
          check(res_way == VEC[i-1][1:0], $sformatf("R2/R3/R5 vec %0d way", i-1),
                res_way, VEC[i-1][1:0]);
          // R8: single way always 0
          check(res_valid1 == 1 && res_way1 == 0, $sformatf("R8 vec %0d", i-1), res_way1, 0);
        end else begin
          // R9 / R4: touch gives no result
          check(res_valid == 0, $sformatf("R9 vec %0d touch quiet", i-1), res_valid, 0);
        end
      end
      if (i < NV) drive(1, VEC[i][7], VEC[i][6:4], VEC[i][3:2]);
      else drive(0, 0, 0, 0);
    end

    // R7: back-pressure hold on set 1 (fresh)
    @(negedge clk);
    res_ready = 1'b0;
    drive(1, 1, 1, 0);
    @(negedge clk);
    check(res_valid == 1 && res_way == 3, "R7 first pick under stall", res_way, 3);
    check(req_ready == 0, "R7 ready low while held", req_ready, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(res_valid == 1 && res_way == 3, "R7 held result stable", res_way, 3);
    end
    res_ready = 1'b1;
    #1;
    check(req_ready == 1, "R7 ready when draining", req_ready, 1);
    @(negedge clk);
    // Held request changed no state: second pick sees one prior pick only
    check(res_valid == 1 && res_way == 1, "R7 second pick after stall", res_way, 1);
    drive(0, 0, 0, 0);
    @(negedge clk);
    check(res_valid == 0, "R7 result drained", res_valid, 0);

    // R8: touches on the single-way instance have no effect
    drive(1, 0, 4, 1);
    @(negedge clk);
    drive(1, 1, 4, 0);
    @(negedge clk);
    drive(0, 0, 0, 0);
    check(res_valid1 == 1 && res_way1 == 0, "R8 pick after touch", res_way1, 0);

    // R1: reset clears history (set 5 was picked once earlier)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(res_valid == 0, "R1 res_valid after second reset", res_valid, 0);
    rst_n = 1'b1;
    drive(1, 1, 5, 0);
    @(negedge clk);
    drive(0, 0, 0, 0);
    check(res_valid == 1 && res_way == 3, "R1 pick after reset", res_way, 3);
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule